// File: doc/BRIEF.md
# Immediate Rounding Shift-Narrow Packer

This block is a vector datapath stage. It takes two 256-bit vectors: a freshly read source, and the value that the destination register holds before the operation. Every element of both vectors is shifted right by an immediate count with round-half-up. Each result is then cut to half its width. The two sets of narrowed results are interleaved into one 256-bit result. The destination's prior value works as a second operand, so the caller must present that value unmodified. The result is formed in full from the inputs of a single strobe, and only then is it handed on for writeback.

Four element sizes are supported: 16→8, 32→16, 64→32 and 128→64. The shift can fill with zeros (logical) or with copies of the sign bit (arithmetic). A mode input selects either one 128-bit lane or two independent 128-bit lanes. The result is registered and appears one cycle after the valid strobe.

Top module: `rsn_pack_top`

## Requirements
- R1: `esize` selects the element size: 0 = 16→8, 1 = 32→16, 2 = 64→32, 3 = 128→64. The shift count is the low 4, 5, 6 or 7 bits of `imm` for these sizes, which is the same as `imm` modulo the element width. Higher `imm` bits are ignored.
- R2: Within a lane, results from `src_new` occupy lane bits 63:0 and results from `dst_old` occupy lane bits 127:64. Narrowed element i of each half sits at bit offset i×(W/2) inside that half, where W is the element width.
- R3: When `wide`=1, lane 1 (result bits 255:128) is built from bits 255:128 of both inputs in the same layout as lane 0.
- R4: When `wide`=0, result bits 255:128 are zero, and input bits 255:128 have no effect on the result.
- R5: For a shift count s>0, an element's result is (element >> s) plus bit s−1 of the original element, truncated to W/2 bits with no saturation. For s=0 the result is the low W/2 bits of the element.
- R6: With `arith`=1 the shift fills with the element's sign bit, including for 128-bit elements. With `arith`=0 it fills with zeros.
- R7: In the 128→64 size with a shift count of zero, each output 64-bit word equals the low 64 bits of the matching 128-bit input element.
- R8: `out_valid` rises exactly one cycle after `in_valid`. `result` updates only on a cycle after `in_valid` was high and otherwise holds. Reset clears `result` to zero and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| src_new | input | 256 | New source vector |
| dst_old | input | 256 | Destination value before the operation |
| imm | input | 7 | Immediate shift count |
| esize | input | 2 | Element size select (R1 codes) |
| arith | input | 1 | 1 = arithmetic shift, 0 = logical |
| wide | input | 1 | 1 = 256-bit mode, 0 = 128-bit mode |
| out_valid | output | 1 | Result valid |
| result | output | 256 | Packed narrowed result |

## Verification
On every cycle, assertions check the one-cycle valid latency and the hold of the result between strobes. They also check that the upper lane is zero after a 128-bit-mode strobe, and that the 128→64 zero-shift bypass copies the low doublewords. The bench covers everything that needs arithmetic. A scoreboard model covers rounding at each element size, sign versus zero fill, the lane packing order, masking of immediate bits above the size, and the effect of upper-lane input data in each mode.

// File: rtl/rsn_pkg.sv
package rsn_pkg;
    localparam int LANE_W    = 128;
    localparam int NUM_LANES = 2;
    localparam int VEC_W     = LANE_W * NUM_LANES;
    localparam int HALF_W    = LANE_W / 2;
    localparam int IMM_W     = $clog2(LANE_W);
    localparam int NUM_SIZES = 4;

    typedef enum logic [1:0] {
        SZ_H2B = 2'd0,
        SZ_W2H = 2'd1,
        SZ_D2W = 2'd2,
        SZ_Q2D = 2'd3
    } rsn_esize_e;

    typedef struct packed {
        rsn_esize_e       esize;
        logic             arith;
        logic [IMM_W-1:0] imm;
    } rsn_ctrl_t;
endpackage

// File: rtl/rsn_narrow.sv
module rsn_narrow
    import rsn_pkg::*;
#(
    parameter int LW = LANE_W
) (
    input  logic [LW-1:0]   vec,
    input  rsn_ctrl_t       ctrl,
    output logic [LW/2-1:0] packed_o
);
    localparam int HW = LW / 2;

    logic [HW-1:0] cand [NUM_SIZES];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        localparam int EW = LW >> (NUM_SIZES - 1 - g);
        localparam int NE = LW / EW;
        localparam int EH = EW / 2;
        localparam int SB = $clog2(EW);

        wire [SB-1:0] sh = ctrl.imm[SB-1:0];
        wire [HW-1:0] pk;

        for (genvar e = 0; e < NE; e++) begin : g_elem
            wire        [EW-1:0] el  = vec[e*EW +: EW];
            wire signed [EW:0]   ext = {ctrl.arith & el[EW-1], el};
            wire signed [EW:0]   shd = ext >>> sh;
            wire        [EW:0]   rb  = {el, 1'b0} >> sh;
            wire        [EH-1:0] rsum = shd[EH-1:0] + {{(EH-1){1'b0}}, rb[0]};
            assign pk[e*EH +: EH] = rsum;
        end
        assign cand[g] = pk;
    end

    always_comb packed_o = cand[ctrl.esize];
endmodule

// File: rtl/rsn_lane.sv
module rsn_lane
    import rsn_pkg::*;
#(
    parameter int LW = LANE_W
) (
    input  logic [LW-1:0] src_lane,
    input  logic [LW-1:0] dst_lane,
    input  rsn_ctrl_t     ctrl,
    output logic [LW-1:0] lane_o
);
    logic [LW/2-1:0] part [2];

    for (genvar p = 0; p < 2; p++) begin : g_part
        rsn_narrow #(.LW(LW)) u_narrow (
            .vec      (p == 0 ? src_lane : dst_lane),
            .ctrl     (ctrl),
            .packed_o (part[p])
        );
    end

    // source results low, old destination results high (R2)
    assign lane_o = {part[1], part[0]};
endmodule

// File: rtl/rsn_pack_top.sv
module rsn_pack_top
    import rsn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] src_new,
    input  logic [VEC_W-1:0] dst_old,
    input  logic [IMM_W-1:0] imm,
    input  logic [1:0]       esize,
    input  logic             arith,
    input  logic             wide,
    output logic             out_valid,
    output logic [VEC_W-1:0] result
);
    rsn_ctrl_t        ctrl;
    logic [VEC_W-1:0] comb_res;

    assign ctrl = '{esize: rsn_esize_e'(esize), arith: arith, imm: imm};

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        logic [LANE_W-1:0] lane_res;
        rsn_lane #(.LW(LANE_W)) u_lane (
            .src_lane (src_new[l*LANE_W +: LANE_W]),
            .dst_lane (dst_old[l*LANE_W +: LANE_W]),
            .ctrl     (ctrl),
            .lane_o   (lane_res)
        );
        if (l == 0) begin : g_base
            assign comb_res[l*LANE_W +: LANE_W] = lane_res;
        end else begin : g_upper
            assign comb_res[l*LANE_W +: LANE_W] = wide ? lane_res : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= comb_res;
        end
    end

    // R8
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R8
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));
    // R4
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide) |=> (result[VEC_W-1:LANE_W] == '0));
    // R7
    quad_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && esize == 2'd3 && imm == '0) |=>
        (result[HALF_W-1:0] == $past(src_new[HALF_W-1:0]) &&
         result[LANE_W-1:HALF_W] == $past(dst_old[HALF_W-1:0])));
endmodule

// File: tb/rsn_pack_top_bench.sv
module rsn_pack_top_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [255:0] src_new = '0;
    logic [255:0] dst_old = '0;
    logic [6:0]   imm = '0;
    logic [1:0]   esize = '0;
    logic         arith = 1'b0;
    logic         wide = 1'b0;
    logic         out_valid;
    logic [255:0] result;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [255:0] exp;
        string        tag;
    } item_t;
    item_t        sb_q[$];
    logic [255:0] last_exp = '0;

    always #10 clk = ~clk;

    rsn_pack_top u_rsn_pack_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_new(src_new),
        .dst_old(dst_old), .imm(imm), .esize(esize), .arith(arith),
        .wide(wide), .out_valid(out_valid), .result(result)
    );

    function automatic logic [255:0] ref_model(logic [255:0] a, logic [255:0] d,
                                               int es, bit ar, bit wd, int im);
        int w = 16 << es;
        int h = w / 2;
        int sh = im % w;
        logic [255:0] m = (256'd1 << w) - 256'd1;
        logic [255:0] mh = (256'd1 << h) - 256'd1;
        logic [255:0] res = '0;
        for (int ln = 0; ln < (wd ? 2 : 1); ln++) begin
            for (int p = 0; p < 2; p++) begin
                for (int i = 0; i < 128 / w; i++) begin
                    logic [255:0] e;
                    logic [255:0] r;
                    e = ((p == 0 ? a : d) >> (ln * 128 + i * w)) & m;
                    if (ar && e[w-1]) e = e | ~m;
                    if (sh == 0) r = e;
                    else r = (e >> sh) + ((e >> (sh - 1)) & 256'd1);
                    res = res | ((r & mh) << (ln * 128 + p * 64 + i * h));
                end
            end
        end
        return res;
    endfunction

    function automatic logic [255:0] rnd256();
        return {$urandom, $urandom, $urandom, $urandom,
                $urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(string tag, logic [255:0] got, logic [255:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic send(logic [255:0] a, logic [255:0] d, int es, bit ar,
                        bit wd, int im, string tag);
        item_t it;
        @(negedge clk);
        src_new = a; dst_old = d; esize = es[1:0]; arith = ar;
        wide = wd; imm = im[6:0]; in_valid = 1'b1;
        it.exp = ref_model(a, d, es, ar, wd, im);
        it.tag = tag;
        sb_q.push_back(it);
        last_exp = it.exp;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            src_new = rnd256(); dst_old = rnd256();
        end
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb_q.size() == 0) begin
                check("R8 unexpected out_valid", 256'd1, 256'd0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, result, it.exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog got=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset result", result, '0);
        check("R8 reset out_valid", {255'd0, out_valid}, '0);
        rst = 1'b0;

        // R5 rounding: 0x0003>>1 rounds up to 2, 0x0001>>1 rounds to 1
        send({16{16'h0003}}, {16{16'h0001}}, 0, 0, 1, 1, "R5 round 16->8");
        send({16{16'h0002}}, {16{16'h0005}}, 0, 0, 1, 2, "R5 round s=2");
        send({16{16'h1234}}, {16{16'hABCD}}, 0, 0, 1, 0, "R5 zero shift truncate");
        // R6 sign fill
        send({8{32'hF000_0001}}, {8{32'h8000_FFFF}}, 1, 1, 1, 4, "R6 arith 32->16");
        send({8{32'hF000_0001}}, {8{32'h8000_FFFF}}, 1, 0, 1, 4, "R6 logical 32->16");
        send({2{128'h8000_0000_0000_0000_0000_0000_0000_0003}},
             {2{128'hFFFF_0000_0000_0000_0000_0000_0000_0000}}, 3, 1, 1, 65,
             "R6 arith 128->64");
        // R7 bypass
        send(rnd256(), rnd256(), 3, 1, 1, 0, "R7 128->64 zero shift");
        send(rnd256(), rnd256(), 3, 0, 0, 0, "R7 bypass narrow mode");
        // R1 imm bits above size ignored
        send(rnd256(), rnd256(), 0, 1, 1, 7'h21, "R1 imm masked 16->8");
        send(rnd256(), rnd256(), 1, 0, 1, 7'h63, "R1 imm masked 32->16");
        send(rnd256(), rnd256(), 2, 1, 1, 7'h7F, "R1 imm masked 64->32");
        // R2 / R3 packing order with distinct lanes
        send({128'h0, 128'h0123_4567_89AB_CDEF_0011_2233_4455_6677},
             {128'hFFEE_DDCC_BBAA_9988_7766_5544_3322_1100, 128'h0},
             2, 0, 1, 8, "R2 lane packing");
        send({128'h1, 128'h0}, {128'h2, 128'h0}, 2, 0, 1, 0, "R3 upper lane");
        // R4 upper input ignored in 128-bit mode
        send({{128{1'b1}}, 128'h55}, {{128{1'b1}}, 128'hAA}, 1, 1, 0, 3,
             "R4 narrow mode upper zero");
        idle(3);
        @(negedge clk);
        check("R8 hold after idle", result, last_exp);
        check("R8 out_valid low when idle", {255'd0, out_valid}, '0);

        // sweep, back-to-back strobes (R8 latency)
        for (int es = 0; es < 4; es++) begin
            for (int ar = 0; ar < 2; ar++) begin
                for (int wd = 0; wd < 2; wd++) begin
                    for (int k = 0; k < 6; k++) begin
                        send(rnd256(), rnd256(), es, ar[0], wd[0],
                             int'($urandom % 128), "R5 R6 R3 sweep");
                    end
                    idle(1 + int'($urandom % 2));
                end
            end
        end
        idle(3);
        @(negedge clk);
        check("R8 final queue drained", {224'd0, 32'(sb_q.size())}, '0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule